// File: doc/BRIEF.md
# Three-Address Instruction Decoder with Index Modification

This block is the decode stage for a 45-bit instruction word that carries three 12-bit address fields. It cuts the word into its fields. Each address field can have one of two index counters added to it, and a per-field modify digit controls this. The stage then labels every resulting address by the storage it selects: fast storage, a drum block, or an input-output station. It also reports when the second address field serves as an extra function bit instead of an address. The block does not execute the operations.

Software-visible sequencing loads the two index counters through a small write port. A word presented with `in_valid` produces its decoded fields, registered, one clock later together with `out_valid`. The operation code steers the decode. Input-output operations never modify their address fields, and low addresses on them name stations. Short-form operations use the low bit of the second field as a function selector, so that field is never indexed.

Word layout, most significant bit first: first address [44:33], second address [32:21], third address [20:9], modify digits m1 [8], m2 [7], m3 [6], counter select [5], opcode [4:1], halt flag [0].

Top module: `triaddr_decode`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `op_code` equals word bits [4:1] of that word. When `in_valid` is low, all decoded outputs hold their previous values.
- R2: A modify digit of 0 (m1 for the first, m2 for the second, m3 for the third field) passes its 12-bit field unchanged to the matching effective address.
- R3: A modify digit of 1 adds an index counter to the field, modulo 4096. Counter select bit [5] chooses the counter: 0 for counter 0, 1 for counter 1.
- R4: A write with `ctr_we` high loads `ctr_wdata` into the counter chosen by `ctr_sel` at the clock edge. A word decoded in the same cycle as the write uses the counter's old value.
- R5: When the operation is not an input-output operation, an effective address of 0x000–0x3FF is classed 0 (fast storage) and 0x400–0xFFF is classed 1 (drum block).
- R6: Opcodes 10 and 11 are input-output operations. All three fields pass unmodified regardless of the modify digits. An address of 0x000–0x00F is classed 2 (station), and other addresses follow R5.
- R7: Opcodes 12–15 are short-form operations. `func_ext` equals bit 0 of the second field, and m2 is ignored. For every other opcode `func_ext` is 0.
- R8: `halt_req` is high when the word's halt flag is 1 and `halt_en` is high in the cycle the word is presented.
- R9: After reset, `out_valid` is 0, all effective addresses are 0, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word is present |
| instr_word | input | 45 | Instruction word |
| halt_en | input | 1 | External stop switch enable |
| ctr_we | input | 1 | Index counter write enable |
| ctr_sel | input | 1 | Counter chosen for write |
| ctr_wdata | input | 12 | Counter write data |
| out_valid | output | 1 | Decoded fields are valid |
| eff_first | output | 12 | Effective first address |
| eff_second | output | 12 | Effective second address |
| eff_third | output | 12 | Effective third address |
| cls_first | output | 2 | Class of first address (0 fast, 1 drum, 2 station) |
| cls_second | output | 2 | Class of second address |
| cls_third | output | 2 | Class of third address |
| op_code | output | 4 | Operation code |
| func_ext | output | 1 | Extra function bit for short-form operations |
| halt_req | output | 1 | Stop requested after this instruction |

## Verification
The stimulus sits on the storage boundary: 0x3FF must stay fast and 0x400 must become drum. A design with an off-by-one compare would misclass one of these. An indexed sum that crosses 0xFFF checks the truncation, and a design that saturates would fail it. Input-output words carry every modify digit set, which catches a design that indexes them anyway. A short-form word with an odd second field and m2 set catches a design that indexes that field or drops the function bit. A counter write issued in the same cycle as a decode checks that the old counter value is used. A design that forwards the new value would report a different effective address.

// File: rtl/tad_pkg.sv
package tad_pkg;
    localparam int ADDR_W  = 12;
    localparam int OP_W    = 4;
    localparam int WORD_W  = 3 * ADDR_W + 4 + OP_W + 1;

    localparam int POS_HALT = 0;
    localparam int POS_OP   = 1;
    localparam int POS_SEL  = POS_OP + OP_W;
    localparam int POS_MOD3 = POS_SEL + 1;
    localparam int POS_F3   = POS_SEL + 4;
    localparam int POS_F2   = POS_F3 + ADDR_W;
    localparam int POS_F1   = POS_F2 + ADDR_W;

    typedef enum logic [1:0] {
        CLS_FAST = 2'd0,
        CLS_DRUM = 2'd1,
        CLS_STN  = 2'd2
    } addr_cls_e;
endpackage

// File: rtl/tad_index_regs.sv
module tad_index_regs #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic          sel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] ctr0,
    output logic [AW-1:0] ctr1
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr0 <= '0;
            ctr1 <= '0;
        end else if (we) begin
            if (sel) ctr1 <= wdata;
            else     ctr0 <= wdata;
        end
    end

    // R4
    ctr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(ctr0) && $stable(ctr1)));
endmodule

// File: rtl/tad_field_mod.sv
module tad_field_mod #(
    parameter int AW = 12
) (
    input  logic [AW-1:0] field,
    input  logic          mod_bit,
    input  logic          block,
    input  logic          ctr_pick,
    input  logic [AW-1:0] ctr0,
    input  logic [AW-1:0] ctr1,
    output logic [AW-1:0] eff
);
    logic [AW-1:0] offs;
    always_comb begin
        offs = ctr_pick ? ctr1 : ctr0;
        if (mod_bit && !block) eff = field + offs;
        else                   eff = field;
    end
endmodule

// File: rtl/tad_addr_class.sv
module tad_addr_class #(
    parameter int AW       = 12,
    parameter int DRUM_LO  = 'h400,
    parameter int STN_TOP  = 'h00F
) (
    input  logic [AW-1:0] addr,
    input  logic          io_op,
    output logic [1:0]    cls
);
    import tad_pkg::*;
    localparam logic [AW-1:0] DRUM_B = AW'(DRUM_LO);
    localparam logic [AW-1:0] STN_B  = AW'(STN_TOP);
    always_comb begin
        if (io_op && addr <= STN_B) cls = CLS_STN;
        else if (addr >= DRUM_B)    cls = CLS_DRUM;
        else                        cls = CLS_FAST;
    end
endmodule

// File: rtl/triaddr_decode.sv
module triaddr_decode
    import tad_pkg::*;
#(
    parameter logic [15:0] IO_OPS  = 16'h0C00,
    parameter logic [15:0] EXT_OPS = 16'hF000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   instr_word,
    input  logic                halt_en,
    input  logic                ctr_we,
    input  logic                ctr_sel,
    input  logic [ADDR_W-1:0]   ctr_wdata,
    output logic                out_valid,
    output logic [ADDR_W-1:0]   eff_first,
    output logic [ADDR_W-1:0]   eff_second,
    output logic [ADDR_W-1:0]   eff_third,
    output logic [1:0]          cls_first,
    output logic [1:0]          cls_second,
    output logic [1:0]          cls_third,
    output logic [OP_W-1:0]     op_code,
    output logic                func_ext,
    output logic                halt_req
);
    localparam int NF = 3;

    logic [ADDR_W-1:0] ctr0, ctr1;
    logic [OP_W-1:0]   op_in;
    logic              io_op, ext_op, ctr_pick;
    logic [ADDR_W-1:0] fld  [NF];
    logic              mbit [NF];
    logic              blk  [NF];
    logic [ADDR_W-1:0] effc [NF];
    logic [1:0]        clsc [NF];

    tad_index_regs #(.AW(ADDR_W)) u_ctrs (
        .clk(clk), .rst_n(rst_n), .we(ctr_we), .sel(ctr_sel),
        .wdata(ctr_wdata), .ctr0(ctr0), .ctr1(ctr1)
    );

    always_comb begin
        op_in    = instr_word[POS_OP +: OP_W];
        io_op    = IO_OPS[op_in];
        ext_op   = EXT_OPS[op_in];
        ctr_pick = instr_word[POS_SEL];
    end

    for (genvar i = 0; i < NF; i++) begin : g_fld
        localparam int FPOS = POS_F1 - i * ADDR_W;
        assign fld[i]  = instr_word[FPOS +: ADDR_W];
        assign mbit[i] = instr_word[POS_MOD3 + (NF - 1 - i)];
        assign blk[i]  = io_op || (i == 1 && ext_op);

        tad_field_mod #(.AW(ADDR_W)) u_mod (
            .field(fld[i]), .mod_bit(mbit[i]), .block(blk[i]),
            .ctr_pick(ctr_pick), .ctr0(ctr0), .ctr1(ctr1), .eff(effc[i])
        );
        tad_addr_class #(.AW(ADDR_W)) u_cls (
            .addr(effc[i]), .io_op(io_op), .cls(clsc[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            eff_first  <= '0;
            eff_second <= '0;
            eff_third  <= '0;
            cls_first  <= CLS_FAST;
            cls_second <= CLS_FAST;
            cls_third  <= CLS_FAST;
            op_code    <= '0;
            func_ext   <= 1'b0;
            halt_req   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                eff_first  <= effc[0];
                eff_second <= effc[1];
                eff_third  <= effc[2];
                cls_first  <= clsc[0];
                cls_second <= clsc[1];
                cls_third  <= clsc[2];
                op_code    <= op_in;
                func_ext   <= ext_op & fld[1][0];
                halt_req   <= instr_word[POS_HALT] & halt_en;
            end
        end
    end

    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(eff_first) && $stable(op_code) && !out_valid));
    // R2
    unmod_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr_word[POS_MOD3 + 2]) |=>
            eff_first == $past(instr_word[POS_F1 +: ADDR_W]));
    // R5
    fast_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cls_first == CLS_FAST) |-> eff_first < 12'h400);
    // R6
    stn_rng_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cls_third == CLS_STN) |-> (eff_third <= 12'h00F && IO_OPS[op_code]));
    // R7
    ext_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && func_ext) |-> EXT_OPS[op_code]);
    // R8
    halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !halt_en) |=> !halt_req);
endmodule

// File: tb/sim_triaddr_decode.sv
module sim_triaddr_decode;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [44:0] instr_word = '0;
    logic        halt_en = 1'b0;
    logic        ctr_we = 1'b0;
    logic        ctr_sel = 1'b0;
    logic [11:0] ctr_wdata = '0;
    logic        out_valid, func_ext, halt_req;
    logic [11:0] eff_first, eff_second, eff_third;
    logic [1:0]  cls_first, cls_second, cls_third;
    logic [3:0]  op_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    triaddr_decode u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr_word(instr_word),
        .halt_en(halt_en), .ctr_we(ctr_we), .ctr_sel(ctr_sel), .ctr_wdata(ctr_wdata),
        .out_valid(out_valid), .eff_first(eff_first), .eff_second(eff_second),
        .eff_third(eff_third), .cls_first(cls_first), .cls_second(cls_second),
        .cls_third(cls_third), .op_code(op_code), .func_ext(func_ext), .halt_req(halt_req)
    );

    // fields: f1 f2 f3 mods(m1 m2 m3 sel) op halt | e1 e2 e3 c1 c2 c3 ext ; ctr0=0x010 ctr1=0xC05
    localparam int NV = 11;
    localparam logic [87:0] VEC [NV] = '{
        {12'h064,12'h0C8,12'h12C,4'b0000,4'h5,1'b1, 12'h064,12'h0C8,12'h12C,2'd0,2'd0,2'd0,1'b0},
        {12'h064,12'h0C8,12'h12C,4'b1110,4'h5,1'b0, 12'h074,12'h0D8,12'h13C,2'd0,2'd0,2'd0,1'b0},
        {12'h064,12'h0C8,12'h12C,4'b1111,4'h5,1'b1, 12'hC69,12'hCCD,12'hD31,2'd1,2'd1,2'd1,1'b0},
        {12'h3FF,12'h400,12'hFFF,4'b1001,4'h5,1'b0, 12'h004,12'h400,12'hFFF,2'd0,2'd1,2'd1,1'b0},
        {12'h3F0,12'h3FF,12'h000,4'b1000,4'h5,1'b0, 12'h400,12'h3FF,12'h000,2'd1,2'd0,2'd0,1'b0},
        {12'h005,12'h010,12'h00F,4'b1111,4'hA,1'b0, 12'h005,12'h010,12'h00F,2'd2,2'd0,2'd2,1'b0},
        {12'h400,12'h00F,12'h3FF,4'b1110,4'hB,1'b1, 12'h400,12'h00F,12'h3FF,2'd1,2'd2,2'd0,1'b0},
        {12'h020,12'h101,12'h200,4'b1110,4'hC,1'b0, 12'h030,12'h101,12'h210,2'd0,2'd0,2'd0,1'b1},
        {12'h000,12'h0FE,12'h000,4'b0100,4'hF,1'b0, 12'h000,12'h0FE,12'h000,2'd0,2'd0,2'd0,1'b0},
        {12'h000,12'h0C9,12'h000,4'b0000,4'h5,1'b0, 12'h000,12'h0C9,12'h000,2'd0,2'd0,2'd0,1'b0},
        {12'h00F,12'h000,12'h000,4'b0000,4'h9,1'b0, 12'h00F,12'h000,12'h000,2'd0,2'd0,2'd0,1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctr(input logic sel, input logic [11:0] d);
        @(negedge clk);
        ctr_we = 1'b1; ctr_sel = sel; ctr_wdata = d;
        @(negedge clk);
        ctr_we = 1'b0;
    endtask

    // drive one word for one cycle; results sampled at the following negedge
    task automatic issue(input logic [44:0] w);
        @(negedge clk);
        in_valid = 1'b1; instr_word = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 out_valid", 32'(out_valid), 0);
        chk("R9 eff_first", 32'(eff_first), 0);
        chk("R9 eff_third", 32'(eff_third), 0);
        rst_n = 1'b1;

        // R9 counters are zero after reset: indexed field stays unchanged
        issue({12'h100,12'h200,12'h300,4'b1110,4'h5,1'b0});
        chk("R9 ctr0 zero", 32'(eff_first), 32'h100);
        chk("R9 ctr0 zero f3", 32'(eff_third), 32'h300);

        wr_ctr(1'b0, 12'h010);
        wr_ctr(1'b1, 12'hC05);
        halt_en = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [87:0] v;
            v = VEC[i];
            issue(v[87:43]);
            chk("R1 out_valid", 32'(out_valid), 1);
            chk("R1 op_code", 32'(op_code), 32'(v[47:44]));
            chk("R2 R3 R6 eff_first", 32'(eff_first), 32'(v[42:31]));
            chk("R2 R3 R7 eff_second", 32'(eff_second), 32'(v[30:19]));
            chk("R2 R3 R6 eff_third", 32'(eff_third), 32'(v[18:7]));
            chk("R5 R6 cls_first", 32'(cls_first), 32'(v[6:5]));
            chk("R5 R6 cls_second", 32'(cls_second), 32'(v[4:3]));
            chk("R5 R6 cls_third", 32'(cls_third), 32'(v[2:1]));
            chk("R7 func_ext", 32'(func_ext), 32'(v[0]));
            chk("R8 halt_req", 32'(halt_req), 32'(v[43]));
        end

        // R1 hold: idle cycle keeps outputs and drops valid
        @(negedge clk);
        chk("R1 idle valid", 32'(out_valid), 0);
        chk("R1 idle hold", 32'(eff_first), 32'h00F);

        // R8 halt flag with switch off
        halt_en = 1'b0;
        issue({12'h001,12'h002,12'h003,4'b0000,4'h5,1'b1});
        chk("R8 halt gated", 32'(halt_req), 0);

        // R4 write in the same cycle as a decode uses the old counter value
        @(negedge clk);
        in_valid = 1'b1;
        instr_word = {12'h100,12'h000,12'h000,4'b1000,4'h5,1'b0};
        ctr_we = 1'b1; ctr_sel = 1'b0; ctr_wdata = 12'h0F0;
        @(negedge clk);
        ctr_we = 1'b0; in_valid = 1'b0;
        chk("R4 old value", 32'(eff_first), 32'h110);
        issue({12'h100,12'h000,12'h000,4'b1000,4'h5,1'b0});
        chk("R4 new value", 32'(eff_first), 32'h1F0);
        // R3 counter 1 unaffected by write to counter 0
        issue({12'h001,12'h000,12'h000,4'b1001,4'h5,1'b0});
        chk("R3 ctr1 kept", 32'(eff_first), 32'hC06);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule